// File: doc/BRIEF.md
# Transmit Fault and Contention Monitor

This block watches a single-wire bus transmitter from the logic side. It compares the transmit level requested by the host with the level read back from the bus. It also times how long either of them stays dominant (low). When the two levels disagree for longer than normal loop delay allows, when a dominant level lasts too long, or when an internal fault is reported, the block pulls a shared open-drain pin low and turns the transmitter off.

The shared pin works in both directions. The block drives it low to report a fault, and it reads it back so that an external device can also hold the transmitter off by pulling the pin low. The pin, the transmit data and the bus level are sampled on a periodic timebase tick. The tick must come faster than every 10 µs; the defaults assume a 1 µs tick.

A control state machine has five states:

- `ST_IDLE`: chip select is low.
- `ST_WAIT_REG`: waiting for the regulator to be reported stable.
- `ST_EXT_OFF`: the pin reads low with no internal fault, so the transmitter is off.
- `ST_FAULT`: the pin is pulled low and the transmitter is off.
- `ST_TX_ON`: the transmitter is enabled.

The transitions are:

- `cs_fall`: any state goes to `ST_IDLE` when chip select is low.
- `cs_rise`: `ST_IDLE` goes to `ST_WAIT_REG`.
- `fault_set`: any state other than `ST_IDLE` goes to `ST_FAULT` when a fault is present.
- `reg_lost`: `ST_EXT_OFF` or `ST_TX_ON` goes to `ST_WAIT_REG` when the regulator is not stable.
- `reg_good`: `ST_WAIT_REG` goes to `ST_EXT_OFF`.
- `pin_high`: `ST_EXT_OFF` goes to `ST_TX_ON` when the sampled pin is high.
- `pin_low`: `ST_TX_ON` goes to `ST_EXT_OFF` when the sampled pin is low.
- `fault_clear`: `ST_FAULT` goes to `ST_EXT_OFF` when the fault has cleared.

The transitions are listed in priority order, highest first.

Top module: `txfault_monitor`

## Requirements
- R1: While reset is asserted and right after it, `tx_en` is 0 and `pin_pull_low` is 0.
- R2: With `cs`=1, `reg_ok`=1, the pin sampled high and no fault present, `tx_en` becomes 1 within 3 clock cycles of `cs` rising.
- R3: A mismatch is `txd` differing from `bus_rx` on a tick while `cs`=1. After `MM_SAMPLES` consecutive mismatched ticks, `pin_pull_low` becomes 1 and `tx_en` becomes 0. After one fewer, both outputs are unchanged.
- R4: Any tick where `txd` equals `bus_rx` restarts the mismatch count from zero.
- R5: While `cs`=0, both outputs are 0, and neither the mismatch count nor the dominant timers advance.
- R6: The pin level is taken only on ticks. A sampled low with no internal fault sets `tx_en` to 0 and leaves `pin_pull_low` at 0. A later sampled high re-enables the transmitter.
- R7: `int_fault`=1 sets `pin_pull_low` to 1 and `tx_en` to 0 by the next cycle. Forcing the pin high from outside while the fault persists does not enable the transmitter.
- R8: After every fault source clears, `pin_pull_low` is released. `tx_en` returns only after a later tick samples the pin high.
- R9: `txd` or `bus_rx` held low (dominant) for `DOM_TICKS` ticks raises a fault. After `DOM_TICKS`-1 ticks there is no fault. The timer clears as soon as that level returns high (recessive), and only then can the fault release.
- R10: When `reg_ok` is 0 at a clock edge, `tx_en` is 0 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle timebase strobe that sets the sampling rate |
| cs | input | 1 | Chip select; the monitor is active while this is high |
| txd | input | 1 | Host transmit level, 0 = dominant |
| bus_rx | input | 1 | Bus level read back from the receiver |
| pin_in | input | 1 | Sensed level of the shared fault/enable pin |
| int_fault | input | 1 | Summary of internal faults (thermal, current limit) |
| reg_ok | input | 1 | Regulator reported stable |
| pin_pull_low | output | 1 | Open-drain pull-down enable for the shared pin |
| tx_en | output | 1 | Internal transmitter enable |

## Verification
The bench drives the mismatch one tick short of the debounce limit and then to the limit. A counter that is off by one would fault on normal propagation delay, or would fault one tick late. It breaks a run of mismatches with a single matching tick; a filter that only holds its count would then fault early. It forces the pin high during an internal fault and then releases the fault while the pin is still sampled low. A design that honoured the external level over the fault, or that skipped the re-sample, would enable the transmitter too soon. It also holds the transmit level dominant to one tick short of the time-out and then to the time-out, and drops the regulator flag. Both checks catch a transmitter left enabled.

// File: rtl/txfm_pkg.sv
package txfm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_REG = 3'd1,
        ST_EXT_OFF  = 3'd2,
        ST_FAULT    = 3'd3,
        ST_TX_ON    = 3'd4
    } txfm_state_t;

    localparam int unsigned TXFM_NUM_TIMERS = 2;

endpackage

// File: rtl/txfm_mismatch_filter.sv
module txfm_mismatch_filter #(
    parameter int unsigned SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic want,
    input  logic seen,
    output logic flagged
);
    localparam int unsigned CW = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0] TOP = CW'(SAMPLES);

    logic [CW-1:0] run_len_q;
    logic          differ;

    assign differ = want ^ seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= '0;
        end else if (!run) begin
            run_len_q <= '0;
        end else if (tick) begin
            if (!differ)
                run_len_q <= '0;
            else if (run_len_q != TOP)
                run_len_q <= run_len_q + 1'b1;
        end
    end

    assign flagged = (run_len_q == TOP);

    // R3: the count never passes its limit
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_len_q <= TOP);

    // R4: a matching sample on a tick restarts the count
    a_r4_match_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !differ) |=> (run_len_q == '0));

    // R5: nothing accrues while deselected
    a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (run_len_q == '0));

endmodule

// File: rtl/txfm_dom_timer.sv
module txfm_dom_timer #(
    parameter int unsigned LIMIT = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic level,
    output logic expired
);
    localparam int unsigned TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] END_CNT = TW'(LIMIT);

    logic [TW-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (!run || level) begin
            held_q <= '0;
        end else if (tick && (held_q != END_CNT)) begin
            held_q <= held_q + 1'b1;
        end
    end

    assign expired = (held_q == END_CNT);

    // R9: a recessive level clears the timer on the next edge
    a_r9_recessive_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (level || !run) |=> !expired);

    // R9: the time-out does not appear unless a tick came while dominant
    a_r9_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!expired && !tick) |=> !expired);

endmodule

// File: rtl/txfm_ctrl_fsm.sv
module txfm_ctrl_fsm
    import txfm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic reg_ok,
    input  logic pin_seen_hi,
    input  logic any_fault,
    output logic pull_low,
    output logic tx_on
);
    txfm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs) state_d = ST_WAIT_REG;                   // cs_rise
            end
            ST_WAIT_REG: begin
                if (!cs)            state_d = ST_IDLE;           // cs_fall
                else if (any_fault) state_d = ST_FAULT;          // fault_set
                else if (reg_ok)    state_d = ST_EXT_OFF;        // reg_good
            end
            ST_EXT_OFF: begin
                if (!cs)            state_d = ST_IDLE;
                else if (any_fault) state_d = ST_FAULT;
                else if (!reg_ok)   state_d = ST_WAIT_REG;       // reg_lost
                else if (pin_seen_hi) state_d = ST_TX_ON;        // pin_high
            end
            ST_TX_ON: begin
                if (!cs)            state_d = ST_IDLE;
                else if (any_fault) state_d = ST_FAULT;
                else if (!reg_ok)   state_d = ST_WAIT_REG;
                else if (!pin_seen_hi) state_d = ST_EXT_OFF;     // pin_low
            end
            ST_FAULT: begin
                if (!cs)             state_d = ST_IDLE;
                else if (!any_fault) state_d = ST_EXT_OFF;       // fault_clear
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_low <= 1'b0;
            tx_on    <= 1'b0;
        end else begin
            pull_low <= (state_d == ST_FAULT);
            tx_on    <= (state_d == ST_TX_ON);
        end
    end

    // R5: deselect turns both outputs off
    a_r5_cs_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (!tx_on && !pull_low));

    // R6: a low pin sample keeps the transmitter off
    a_r6_pin_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_seen_hi |=> !tx_on);

    // R10: regulator not stable means no transmit
    a_r10_reg_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_ok |=> !tx_on);

    // R7: outputs are never both active
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_on && pull_low));

endmodule

// File: rtl/txfault_monitor.sv
module txfault_monitor
    import txfm_pkg::*;
#(
    parameter int unsigned MM_SAMPLES = 4,
    parameter int unsigned DOM_TICKS  = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cs,
    input  logic txd,
    input  logic bus_rx,
    input  logic pin_in,
    input  logic int_fault,
    input  logic reg_ok,
    output logic pin_pull_low,
    output logic tx_en
);
    logic                        pin_smp_q;
    logic                        mm_flag;
    logic [TXFM_NUM_TIMERS-1:0]  dom_lvl;
    logic [TXFM_NUM_TIMERS-1:0]  dom_to;
    logic                        any_fault;

    // pin sampled only on timebase ticks; idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pin_smp_q <= 1'b1;
        else if (tick) pin_smp_q <= pin_in;
    end

    txfm_mismatch_filter #(.SAMPLES(MM_SAMPLES)) u_mm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (cs),
        .want    (txd),
        .seen    (bus_rx),
        .flagged (mm_flag)
    );

    assign dom_lvl = {bus_rx, txd};

    for (genvar g = 0; g < TXFM_NUM_TIMERS; g++) begin : g_dom
        txfm_dom_timer #(.LIMIT(DOM_TICKS)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .run     (cs),
            .level   (dom_lvl[g]),
            .expired (dom_to[g])
        );
    end

    assign any_fault = mm_flag | (|dom_to) | int_fault;

    txfm_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs          (cs),
        .reg_ok      (reg_ok),
        .pin_seen_hi (pin_smp_q),
        .any_fault   (any_fault),
        .pull_low    (pin_pull_low),
        .tx_on       (tx_en)
    );

    // R7: an internal fault takes the transmitter down on the next edge
    a_r7_int_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        int_fault |=> !tx_en);

    // R8: enable never appears while any fault source is active
    a_r8_no_enable_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (any_fault && !tx_en) |=> !tx_en);

endmodule

// File: tb/sim_txfault_monitor.sv
`timescale 1ns/1ps
module sim_txfault_monitor;
    localparam int unsigned NS = 4;
    localparam int unsigned ND = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, cs = 1'b0, txd = 1'b1, bus_rx = 1'b1;
    logic int_fault = 1'b0, reg_ok = 1'b1;
    logic ext_low = 1'b0, force_hi = 1'b0;
    logic pin_in, pin_pull_low, tx_en;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    // open-drain pin model with external pull-up
    assign pin_in = force_hi ? 1'b1 : ~(pin_pull_low | ext_low);

    txfault_monitor #(.MM_SAMPLES(NS), .DOM_TICKS(ND)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .txd(txd),
        .bus_rx(bus_rx), .pin_in(pin_in), .int_fault(int_fault),
        .reg_ok(reg_ok), .pin_pull_low(pin_pull_low), .tx_en(tx_en)
    );

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs = 1'b0; txd = 1'b1; bus_rx = 1'b1;
        int_fault = 1'b0; reg_ok = 1'b1; ext_low = 1'b0; force_hi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bring_up();
        cs = 1'b1;
        settle();
        check(tx_en, 1'b1, "R2 enable after cs");
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(tx_en, 1'b0, "R1 tx_en in reset");
        check(pin_pull_low, 1'b0, "R1 pull in reset");
        do_reset();
        check(tx_en, 1'b0, "R1 tx_en after reset");
        check(pin_pull_low, 1'b0, "R1 pull after reset");
    endtask

    task automatic t_mismatch();
        do_reset(); bring_up();
        txd = 1'b0; bus_rx = 1'b1;
        ticks(NS - 1); settle();
        check(pin_pull_low, 1'b0, "R3 no fault one short");
        check(tx_en, 1'b1, "R3 still enabled one short");
        ticks(1); settle();
        check(pin_pull_low, 1'b1, "R3 fault at limit");
        check(tx_en, 1'b0, "R3 tx off at limit");
    endtask

    task automatic t_match_restart();
        do_reset(); bring_up();
        txd = 1'b0; bus_rx = 1'b1; ticks(NS - 1);
        bus_rx = 1'b0; ticks(1);
        bus_rx = 1'b1; ticks(NS - 1); settle();
        check(pin_pull_low, 1'b0, "R4 match restarts count");
        check(tx_en, 1'b1, "R4 still enabled");
        ticks(1); settle();
        check(pin_pull_low, 1'b1, "R4 full run after restart faults");
    endtask

    task automatic t_cs_low();
        do_reset();
        txd = 1'b0; bus_rx = 1'b1;
        ticks(NS + 6); settle();
        check(pin_pull_low, 1'b0, "R5 no pull while deselected");
        check(tx_en, 1'b0, "R5 no enable while deselected");
        cs = 1'b1; settle();
        check(tx_en, 1'b1, "R5 nothing accrued while deselected");
        ticks(NS - 1); settle();
        check(pin_pull_low, 1'b0, "R5 count started from zero");
    endtask

    task automatic t_ext_pin();
        do_reset(); bring_up();
        ext_low = 1'b1; settle();
        check(tx_en, 1'b1, "R6 pin not sampled between ticks");
        ticks(1); settle();
        check(tx_en, 1'b0, "R6 external low disables");
        check(pin_pull_low, 1'b0, "R6 no pull on external low");
        ext_low = 1'b0; ticks(1); settle();
        check(tx_en, 1'b1, "R6 sampled high re-enables");
    endtask

    task automatic t_int_fault();
        do_reset(); bring_up();
        int_fault = 1'b1; @(negedge clk); @(negedge clk);
        check(pin_pull_low, 1'b1, "R7 pull on internal fault");
        check(tx_en, 1'b0, "R7 tx off on internal fault");
        force_hi = 1'b1; ticks(3); settle();
        check(tx_en, 1'b0, "R7 forced high does not enable");
        force_hi = 1'b0; ticks(1);
        int_fault = 1'b0; settle();
        check(pin_pull_low, 1'b0, "R8 pull released");
        check(tx_en, 1'b0, "R8 waits for pin sample");
        ticks(1); settle();
        check(tx_en, 1'b1, "R8 enable after pin sampled high");
    endtask

    task automatic t_dominant();
        do_reset(); bring_up();
        txd = 1'b0; bus_rx = 1'b0;
        ticks(ND - 1); settle();
        check(pin_pull_low, 1'b0, "R9 no time-out one short");
        ticks(1); settle();
        check(pin_pull_low, 1'b1, "R9 time-out fault");
        check(tx_en, 1'b0, "R9 tx off on time-out");
        txd = 1'b1; bus_rx = 1'b1; settle();
        check(pin_pull_low, 1'b0, "R9 release after recessive");
        ticks(1); settle();
        check(tx_en, 1'b1, "R9 enable after release");
    endtask

    task automatic t_regulator();
        do_reset(); bring_up();
        @(negedge clk) reg_ok = 1'b0;
        @(negedge clk);
        check(tx_en, 1'b0, "R10 off when regulator unstable");
        reg_ok = 1'b1; settle();
        check(tx_en, 1'b1, "R10 back on when stable");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_mismatch();
        t_match_restart();
        t_cs_low();
        t_ext_pin();
        t_int_fault();
        t_dominant();
        t_regulator();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule